// File: doc/BRIEF.md
# Fractional Sample-Rate Strobe Generator

This block derives a sample-rate strobe from one of two reference sample-rate strobes, one running at 44.1 kHz and the other at 48 kHz. A Bresenham-style accumulator adds a programmed increment on every selected reference strobe. Each time the sum reaches a programmed modulus, the block subtracts the modulus and emits one output strobe. The output rate is therefore the reference rate times increment over modulus. The pulses are spread as evenly as the ratio allows.

Two write-only registers configure the block. The source register picks the reference family. The divider register packs the increment together with a pre-encoded form of the modulus. Software normally programs an increment of 4 and a modulus of 4 × reference / target. This covers output rates from 8000 to 48000 samples per second. A chip normally carries two instances, one timing playback and one timing record. Each audio channel picks its instance by a clock number of 1 or 2.

Top module: `rate_strobe_gen`

## Requirements
- R1: After reset the output is low, the source is the 48 kHz reference, and the increment and encoded field are zero. Until the divider register is written, no output strobe occurs for any reference activity.
- R2: A write to the source register takes bit 0 of the data bus. A value of 1 selects the 44.1 kHz reference strobe and 0 selects the 48 kHz one. Strobes on the unselected reference have no effect on the output.
- R3: A write to the divider register takes the increment from data bits 15:0 and an encoded field from bits 31:16. The modulus is increment − field − 1, taken modulo 2^16.
- R4: On each selected reference strobe with a nonzero modulus greater than the increment, the accumulator adds the increment. If the sum is at least the modulus, the modulus is subtracted and an output strobe is produced. With no reference strobe, the accumulator holds and no output strobe is produced.
- R5: An output strobe is a single-cycle high pulse. It appears exactly one clock after the reference strobe that caused it. There is at most one output strobe per reference strobe.
- R6: A write to either register clears the accumulator to zero. A reference strobe in the same cycle as the write is not counted and produces no output strobe.
- R7: When the modulus is nonzero and the increment is greater than or equal to it, every selected reference strobe produces an output strobe.
- R8: When the modulus is zero, no output strobe is ever produced.
- R9: Starting from a cleared accumulator, N selected reference strobes produce exactly floor(N × increment / modulus) output strobes, for increment below modulus.
- R10: Between two successive output strobes, the number of selected reference strobes is either floor(modulus / increment) or ceil(modulus / increment).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrSrc | input | 1 | Write strobe for the source register |
| wrDiv | input | 1 | Write strobe for the divider register |
| wrData | input | 32 | Write data for both registers |
| ref441Tick | input | 1 | One-cycle strobe at the 44.1 kHz reference rate |
| ref48Tick | input | 1 | One-cycle strobe at the 48 kHz reference rate |
| rateTick | output | 1 | Generated sample-rate strobe |

## Verification
The bench targets the modulus decode first. A field built from 4 − mod − 1 wraps below zero for every real rate. A design that dropped the wrap or the −1 would count the wrong ratio and miss the 100-of-600 and 40-of-80 counts. Non-integer ratios such as 3/7 are checked for gaps of only 2 or 3 reference strobes; an accumulator that reset to zero instead of keeping the remainder would drift to a constant gap and lose pulses. The bench also covers a write landing together with a reference strobe, increments at or above the modulus, a zero modulus, and strobes on the unselected reference. A generator that got these wrong would count a stale tick, wrap its accumulator, emit on a zero modulus, or follow the wrong reference.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
  // Strobes from the control side to the accumulator datapath
  typedef struct packed {
    logic accClear;  // a register write happened this cycle
    logic accStep;   // selected reference strobe, no write pending
  } accCtrl_t;
endpackage

// File: rtl/rsg_ctrl.sv
module rsg_ctrl
  import rsg_pkg::*;
#(
  parameter int FIELD_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrSrc,
  input  logic                 wrDiv,
  input  logic [2*FIELD_W-1:0] wrData,
  input  logic                 ref441Tick,
  input  logic                 ref48Tick,
  output accCtrl_t             ctrlStrb,
  output logic [FIELD_W-1:0]   incVal,
  output logic [FIELD_W-1:0]   fieldVal
);
  localparam int DATA_W = 2 * FIELD_W;

  logic  srcIs441;
  logic  selTick;
  logic  anyWrite;

  // Register bank: source select and packed divider
  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcIs441 <= 1'b0;
      incVal   <= '0;
      fieldVal <= '0;
    end else begin
      if (wrSrc) srcIs441 <= wrData[0];
      if (wrDiv) begin
        incVal   <= wrData[FIELD_W-1:0];
        fieldVal <= wrData[DATA_W-1:FIELD_W];
      end
    end
  end

  always_comb begin
    anyWrite          = wrSrc | wrDiv;
    selTick           = srcIs441 ? ref441Tick : ref48Tick;
    ctrlStrb.accClear = anyWrite;
    ctrlStrb.accStep  = selTick & ~anyWrite;
  end
endmodule

// File: rtl/rsg_datapath.sv
module rsg_datapath
  import rsg_pkg::*;
#(
  parameter int FIELD_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  accCtrl_t           ctrlStrb,
  input  logic [FIELD_W-1:0] incVal,
  input  logic [FIELD_W-1:0] fieldVal,
  output logic               rateTick
);
  localparam int SUM_W = FIELD_W + 1;

  logic [FIELD_W-1:0] accQ;
  logic [FIELD_W-1:0] modVal;
  logic [SUM_W-1:0]   sumVal;
  logic               modZero;
  logic               incWide;
  logic               wrapHit;

  always_comb begin
    modVal  = incVal - fieldVal - FIELD_W'(1);
    modZero = (modVal == '0);
    incWide = (incVal >= modVal);
    sumVal  = {1'b0, accQ} + {1'b0, incVal};
    wrapHit = (sumVal >= {1'b0, modVal});
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctrlStrb.accClear) begin
      accQ     <= '0;
      rateTick <= 1'b0;
    end else if (ctrlStrb.accStep) begin
      if (modZero) begin
        accQ     <= '0;
        rateTick <= 1'b0;
      end else if (incWide) begin
        accQ     <= '0;
        rateTick <= 1'b1;
      end else if (wrapHit) begin
        accQ     <= FIELD_W'(sumVal - {1'b0, modVal});
        rateTick <= 1'b1;
      end else begin
        accQ     <= FIELD_W'(sumVal);
        rateTick <= 1'b0;
      end
    end else begin
      rateTick <= 1'b0;
    end
  end
endmodule

// File: rtl/rate_strobe_gen.sv
module rate_strobe_gen
  import rsg_pkg::*;
#(
  parameter int FIELD_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrSrc,
  input  logic                 wrDiv,
  input  logic [2*FIELD_W-1:0] wrData,
  input  logic                 ref441Tick,
  input  logic                 ref48Tick,
  output logic                 rateTick
);
  accCtrl_t           ctrlStrb;
  logic [FIELD_W-1:0] incVal;
  logic [FIELD_W-1:0] fieldVal;

  rsg_ctrl #(.FIELD_W(FIELD_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .wrSrc      (wrSrc),
    .wrDiv      (wrDiv),
    .wrData     (wrData),
    .ref441Tick (ref441Tick),
    .ref48Tick  (ref48Tick),
    .ctrlStrb   (ctrlStrb),
    .incVal     (incVal),
    .fieldVal   (fieldVal)
  );

  rsg_datapath #(.FIELD_W(FIELD_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlStrb (ctrlStrb),
    .incVal   (incVal),
    .fieldVal (fieldVal),
    .rateTick (rateTick)
  );
endmodule

// File: rtl/rsg_checker.sv
module rsg_checker (
  input logic clk,
  input logic rstN,
  input logic wrSrc,
  input logic wrDiv,
  input logic ref441Tick,
  input logic ref48Tick,
  input logic stepSeen,
  input logic rateTick
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !rateTick); // R1

  AST_STEP_FROM_REF: assert property (@(posedge clk) disable iff (!rstN)
    stepSeen |-> (ref441Tick || ref48Tick)); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !(ref441Tick || ref48Tick) |=> !rateTick); // R4

  AST_STROBE_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rstN)
    rateTick |-> $past(stepSeen)); // R5

  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (wrSrc || wrDiv) |=> !rateTick); // R6
endmodule

bind rate_strobe_gen rsg_checker chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .wrSrc      (wrSrc),
  .wrDiv      (wrDiv),
  .ref441Tick (ref441Tick),
  .ref48Tick  (ref48Tick),
  .stepSeen   (ctrlStrb.accStep),
  .rateTick   (rateTick)
);

// File: tb/rate_strobe_gen_tb_top.sv
`timescale 1ns/1ps
module rate_strobe_gen_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrSrc = 1'b0;
  logic        wrDiv = 1'b0;
  logic [31:0] wrData = '0;
  logic        ref441Tick = 1'b0;
  logic        ref48Tick = 1'b0;
  logic        rateTick;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  bit          mSrc;
  logic [15:0] mInc, mField, mAcc;
  bit          expOut;
  // observation statistics
  int stepCnt, outCnt, sinceOut, gapLo, gapHi;

  always #2 clk = ~clk;  // 250 MHz

  rate_strobe_gen dut_i (
    .clk(clk), .rstN(rstN), .wrSrc(wrSrc), .wrDiv(wrDiv), .wrData(wrData),
    .ref441Tick(ref441Tick), .ref48Tick(ref48Tick), .rateTick(rateTick)
  );

  function automatic logic [15:0] fieldFor(int inc, int modv);
    return 16'(inc - modv - 1);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic clearStats();
    stepCnt = 0; outCnt = 0; sinceOut = 0; gapLo = 1 << 30; gapHi = 0;
  endtask

  // Drive one cycle, advance the model, sample after the edge
  task automatic doCycle(input bit a, input bit b, input bit ws, input bit wd,
                         input logic [31:0] d, input string tag);
    logic [15:0] modv;
    logic [16:0] sum;
    ref441Tick = a; ref48Tick = b; wrSrc = ws; wrDiv = wd; wrData = d;
    expOut = 0;
    if (ws || wd) begin
      if (ws) mSrc = d[0];
      if (wd) begin mInc = d[15:0]; mField = d[31:16]; end
      mAcc = 0;
    end else if (mSrc ? a : b) begin
      stepCnt++; sinceOut++;
      modv = 16'(mInc - mField - 16'd1);
      if (modv == 0) mAcc = 0;
      else if (mInc >= modv) begin mAcc = 0; expOut = 1; end
      else begin
        sum = {1'b0, mAcc} + {1'b0, mInc};
        if (sum >= {1'b0, modv}) begin mAcc = 16'(sum - {1'b0, modv}); expOut = 1; end
        else mAcc = sum[15:0];
      end
    end
    @(posedge clk); #1;
    check(rateTick === expOut, tag, int'(rateTick), int'(expOut));
    if (rateTick === 1'b1) begin
      if (outCnt > 0) begin
        if (sinceOut < gapLo) gapLo = sinceOut;
        if (sinceOut > gapHi) gapHi = sinceOut;
      end
      outCnt++; sinceOut = 0;
    end
    ref441Tick = 0; ref48Tick = 0; wrSrc = 0; wrDiv = 0;
  endtask

  task automatic setSrc(input bit s);
    doCycle(0, 0, 1, 0, {31'd0, s}, "R2");
  endtask

  task automatic setDiv(input int inc, input int modv);
    doCycle(0, 0, 0, 1, {fieldFor(inc, modv), 16'(inc)}, "R3");
  endtask

  // n selected strobes on one reference, one idle cycle between each
  task automatic runRef(input bit use441, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      doCycle(use441, !use441, 0, 0, '0, tag);
      doCycle(0, 0, 0, 0, '0, tag);
    end
  endtask

  initial begin
    void'($urandom(32'd7741));
    mSrc = 0; mInc = 0; mField = 0; mAcc = 0;
    clearStats();
    repeat (3) @(posedge clk);
    #1;
    check(rateTick === 1'b0, "R1 reset output", int'(rateTick), 0);
    rstN = 1;
    // R1: unprogrammed divider never strobes
    clearStats();
    for (int i = 0; i < 20; i++) doCycle(1, 1, 0, 0, '0, "R1");
    check(outCnt == 0, "R1 idle after reset", outCnt, 0);

    // R3 R9 R10: 44.1k reference, ratio 4/8
    setSrc(1);
    setDiv(4, 8);
    clearStats();
    runRef(1, 80, "R4");
    check(outCnt == 40, "R9 count 4/8", outCnt, 40);
    check(gapLo == 2 && gapHi == 2, "R10 gap 4/8", gapHi, 2);
    // R2: unselected 48k reference ignored
    clearStats();
    runRef(0, 40, "R2");
    check(outCnt == 0, "R2 unselected ignored", outCnt, 0);

    // R9 R10: 48k reference, 8 kHz target (mod 24)
    setSrc(0);
    setDiv(4, 24);
    clearStats();
    runRef(0, 600, "R4");
    check(outCnt == 100, "R9 count 4/24", outCnt, 100);
    check(gapLo == 6 && gapHi == 6, "R10 gap 4/24", gapLo, 6);

    // R9 R10: uneven ratio 3/7
    setDiv(3, 7);
    clearStats();
    runRef(0, 70, "R4");
    check(outCnt == 30, "R9 count 3/7", outCnt, 30);
    check(gapLo == 2 && gapHi == 3, "R10 gap 3/7", gapLo * 10 + gapHi, 23);

    // R6: write clears remainder; write with coincident tick is not counted
    runRef(0, 2, "R6");
    doCycle(0, 1, 0, 1, {fieldFor(3, 7), 16'd3}, "R6 write with tick");
    clearStats();
    runRef(0, 7, "R6");
    check(outCnt == 3, "R6 restart from zero", outCnt, 3);

    // R5 R7: increment at or above modulus, back-to-back ticks
    setDiv(5, 3);
    clearStats();
    for (int i = 0; i < 12; i++) doCycle(0, 1, 0, 0, '0, "R5 R7");
    check(outCnt == 12, "R7 every tick", outCnt, 12);
    setDiv(4, 4);
    clearStats();
    runRef(0, 10, "R7");
    check(outCnt == 10, "R7 inc equals mod", outCnt, 10);

    // R8: zero modulus
    setDiv(4, 0);
    clearStats();
    runRef(0, 30, "R8");
    check(outCnt == 0, "R8 zero modulus", outCnt, 0);

    // Constrained random mix, checked cycle by cycle against the model
    for (int i = 0; i < 4000; i++) begin
      int pick;
      pick = int'($urandom % 60);
      if (pick == 0) setSrc(1'($urandom % 2));
      else if (pick == 1) setDiv(1 + int'($urandom % 12), 1 + int'($urandom % 40));
      else doCycle(($urandom % 3) == 0, ($urandom % 2) == 0,
                   0, 0, '0, "R4 random");
    end

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule